// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns a 32-bit instruction word from a small 64-bit integer subset (register add, subtract, and, or; add-immediate; doubleword load; doubleword store; branch-if-equal) into the control signals of a single-issue datapath. It is purely combinational. It has two stages. The first stage looks only at the 7-bit opcode. It raises the branch, memory-read, load-writeback, memory-write, immediate-operand and register-write strobes, and it assigns the word to one of four operation classes. The second stage takes that class together with instruction bit 30 and the funct3 field (bits 14 to 12) and produces a 4-bit ALU operation select.

A surrounding datapath feeds the fetched word into `insn` and routes the outputs to its operand mux, write-back mux, memory strobes and branch logic. Any opcode outside the supported set yields an all-zero control word, so no register or memory state can change and no branch can be taken.

Top module: `ctrl_decoder`

## Requirements
- R1: `alu_class` is 00 for opcode 0110011 (register ops), 01 for opcode 0010011 (add-immediate) and 0000011 (load), 10 for opcode 0100011 (store), and 11 for opcode 1100011 (branch-if-equal).
- R2: `br_en` is 1 only for opcode 1100011.
- R3: `mem_rd` and `wb_from_mem` are 1 only for opcode 0000011.
- R4: `mem_wr` is 1 only for opcode 0100011.
- R5: `op_b_imm` is 1 for opcodes 0010011, 0000011 and 0100011, and 0 for all others.
- R6: `rf_we` is 1 for opcodes 0110011, 0010011 and 0000011, and 0 for all others.
- R7: For a register op with funct3 000, `alu_sel` is 0110 (subtract) when bit 30 is 1 and 0010 (add) when bit 30 is 0.
- R8: For a register op, funct3 111 gives `alu_sel` 0000 (and) and funct3 110 gives 0001 (or), whatever bit 30 is. Any other funct3 gives 0000.
- R9: Add-immediate, load and store always give `alu_sel` 0010, whatever funct3 and bit 30 are.
- R10: Branch-if-equal always gives `alu_sel` 0110, so that a zero result signals equality.
- R11: Any other opcode drives every output to zero, `alu_class` and `alu_sel` included.
- R12: Instruction bits other than 6:0, 14:12 and 30 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 32 | Instruction word being decoded |
| br_en | output | 1 | Conditional branch instruction |
| mem_rd | output | 1 | Data memory read strobe |
| wb_from_mem | output | 1 | Write-back value taken from memory |
| mem_wr | output | 1 | Data memory write strobe |
| op_b_imm | output | 1 | Second ALU operand taken from the immediate |
| rf_we | output | 1 | Register file write enable |
| alu_class | output | 2 | Operation class handed to ALU selection |
| alu_sel | output | 4 | ALU operation select |

## Verification
The opcode stage and the ALU-select stage both work on the same word in the same evaluation, so a word whose funct3 and bit 30 would name and, or or subtract under a register op tests whether the second stage follows the class or the raw bits. The bench sends store, load, add-immediate and branch words with funct3 set to 111 or 110 and bit 30 set. It also sends a register op with every field outside the decoded bits set to 1. In each case it compares the complete control word against a value worked out from the requirements.

// File: rtl/ctrl_decoder.sv
module ctrl_decoder (
  input  logic [31:0] insn,
  output logic        br_en,
  output logic        mem_rd,
  output logic        wb_from_mem,
  output logic        mem_wr,
  output logic        op_b_imm,
  output logic        rf_we,
  output logic [1:0]  alu_class,
  output logic [3:0]  alu_sel
);

  localparam logic [6:0] OPC_REG  = 7'b0110011;
  localparam logic [6:0] OPC_IMM  = 7'b0010011;
  localparam logic [6:0] OPC_LOAD = 7'b0000011;
  localparam logic [6:0] OPC_STOR = 7'b0100011;
  localparam logic [6:0] OPC_BEQ  = 7'b1100011;

  localparam logic [1:0] CLS_REG = 2'b00;
  localparam logic [1:0] CLS_IMM = 2'b01;
  localparam logic [1:0] CLS_STO = 2'b10;
  localparam logic [1:0] CLS_BR  = 2'b11;

  localparam logic [3:0] ALU_AND = 4'b0000;
  localparam logic [3:0] ALU_OR  = 4'b0001;
  localparam logic [3:0] ALU_ADD = 4'b0010;
  localparam logic [3:0] ALU_SUB = 4'b0110;

  wire [6:0] opc   = insn[6:0];
  wire [2:0] f3    = insn[14:12];
  wire       alt   = insn[30];

  logic known;

  always_comb begin
    known       = 1'b1;
    br_en       = 1'b0;
    mem_rd      = 1'b0;
    wb_from_mem = 1'b0;
    mem_wr      = 1'b0;
    op_b_imm    = 1'b0;
    rf_we       = 1'b0;
    alu_class   = CLS_REG;
    case (opc)
      OPC_REG: begin
        rf_we = 1'b1;
      end
      OPC_IMM: begin
        op_b_imm  = 1'b1;
        rf_we     = 1'b1;
        alu_class = CLS_IMM;
      end
      OPC_LOAD: begin
        mem_rd      = 1'b1;
        wb_from_mem = 1'b1;
        op_b_imm    = 1'b1;
        rf_we       = 1'b1;
        alu_class   = CLS_IMM;
      end
      OPC_STOR: begin
        mem_wr    = 1'b1;
        op_b_imm  = 1'b1;
        alu_class = CLS_STO;
      end
      OPC_BEQ: begin
        br_en     = 1'b1;
        alu_class = CLS_BR;
      end
      default: known = 1'b0;
    endcase
  end

  logic [3:0] reg_sel;

  always_comb begin
    case (f3)
      3'b000:  reg_sel = alt ? ALU_SUB : ALU_ADD;
      3'b111:  reg_sel = ALU_AND;
      3'b110:  reg_sel = ALU_OR;
      default: reg_sel = ALU_AND;
    endcase
  end

  always_comb begin
    case (alu_class)
      CLS_REG: alu_sel = known ? reg_sel : 4'b0000;
      CLS_BR:  alu_sel = ALU_SUB;
      default: alu_sel = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/ctrl_decoder_chk.sv
module ctrl_decoder_chk (
  input logic [31:0] insn,
  input logic        br_en,
  input logic        mem_rd,
  input logic        wb_from_mem,
  input logic        mem_wr,
  input logic        op_b_imm,
  input logic        rf_we,
  input logic [1:0]  alu_class,
  input logic [3:0]  alu_sel
);

  always_comb begin
    if (!$isunknown(insn)) begin
      // R3
      load_pair_chk: assert (mem_rd == wb_from_mem);
      // R4
      rd_wr_excl_chk: assert (!(mem_rd && mem_wr));
      // R6
      load_writes_chk: assert (!mem_rd || (rf_we && op_b_imm && alu_class == 2'b01 && alu_sel == 4'b0010));
      // R5
      store_shape_chk: assert (!mem_wr || (op_b_imm && !rf_we && alu_class == 2'b10 && alu_sel == 4'b0010));
      // R10
      branch_shape_chk: assert (!br_en || (alu_sel == 4'b0110 && alu_class == 2'b11 && !rf_we && !op_b_imm));
      // R11
      idle_zero_chk: assert (rf_we || br_en || mem_wr || (alu_class == 2'b00 && alu_sel == 4'b0000 && !op_b_imm));
      // R7
      sub_class_chk: assert (!(alu_sel == 4'b0110 && !br_en) || (alu_class == 2'b00 && insn[30]));
    end
  end

endmodule

bind ctrl_decoder ctrl_decoder_chk u_ctrl_decoder_chk (.*);

// File: tb/test_ctrl_decoder.sv
module test_ctrl_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn = 32'h0;
  logic        br_en, mem_rd, wb_from_mem, mem_wr, op_b_imm, rf_we;
  logic [1:0]  alu_class;
  logic [3:0]  alu_sel;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  ctrl_decoder i_ctrl_decoder (
    .insn(insn), .br_en(br_en), .mem_rd(mem_rd), .wb_from_mem(wb_from_mem),
    .mem_wr(mem_wr), .op_b_imm(op_b_imm), .rf_we(rf_we),
    .alu_class(alu_class), .alu_sel(alu_sel)
  );

  localparam logic [6:0] O_REG = 7'b0110011;
  localparam logic [6:0] O_IMM = 7'b0010011;
  localparam logic [6:0] O_LD  = 7'b0000011;
  localparam logic [6:0] O_SD  = 7'b0100011;
  localparam logic [6:0] O_BR  = 7'b1100011;

  // control word order: br, mem_rd, wb_from_mem, mem_wr, op_b_imm, rf_we, class[1:0], sel[3:0]
  localparam logic [11:0] W_ADD  = 12'b000001_00_0010;
  localparam logic [11:0] W_SUB  = 12'b000001_00_0110;
  localparam logic [11:0] W_AND  = 12'b000001_00_0000;
  localparam logic [11:0] W_OR   = 12'b000001_00_0001;
  localparam logic [11:0] W_ADDI = 12'b000011_01_0010;
  localparam logic [11:0] W_LD   = 12'b011011_01_0010;
  localparam logic [11:0] W_SD   = 12'b000110_10_0010;
  localparam logic [11:0] W_BR   = 12'b100000_11_0110;
  localparam logic [11:0] W_NONE = 12'b000000_00_0000;

  function automatic logic [31:0] mk(input logic [6:0] op, input logic [2:0] f3,
                                     input logic b30, input logic fill);
    logic [31:0] w;
    w = {32{fill}};
    w[6:0]   = op;
    w[14:12] = f3;
    w[30]    = b30;
    return w;
  endfunction

  task automatic apply_check(input string req, input logic [31:0] w, input logic [11:0] exp);
    logic [11:0] got;
    @(negedge clk);
    insn = w;
    #2;
    got = {br_en, mem_rd, wb_from_mem, mem_wr, op_b_imm, rf_we, alu_class, alu_sel};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s insn=%h actual=%b expected=%b", req, w, got, exp);
    end
  endtask

  task automatic t_reset_state;
    // R11: all-zero word (opcode 0000000) decodes to nothing
    apply_check("R11", 32'h0000_0000, W_NONE);
  endtask

  task automatic t_register_ops;
    apply_check("R7", mk(O_REG, 3'b000, 1'b0, 1'b0), W_ADD);
    apply_check("R7", mk(O_REG, 3'b000, 1'b1, 1'b0), W_SUB);
    apply_check("R8", mk(O_REG, 3'b111, 1'b0, 1'b0), W_AND);
    apply_check("R8", mk(O_REG, 3'b111, 1'b1, 1'b0), W_AND);
    apply_check("R8", mk(O_REG, 3'b110, 1'b0, 1'b0), W_OR);
    apply_check("R8", mk(O_REG, 3'b110, 1'b1, 1'b0), W_OR);
    apply_check("R8", mk(O_REG, 3'b001, 1'b0, 1'b0), W_AND);
    apply_check("R8", mk(O_REG, 3'b100, 1'b1, 1'b0), W_AND);
  endtask

  task automatic t_memory_and_imm;
    // R1 R3 R5 R6 R9
    apply_check("R3", mk(O_LD, 3'b011, 1'b0, 1'b0), W_LD);
    apply_check("R9", mk(O_LD, 3'b111, 1'b1, 1'b0), W_LD);
    apply_check("R4", mk(O_SD, 3'b011, 1'b0, 1'b0), W_SD);
    apply_check("R9", mk(O_SD, 3'b110, 1'b1, 1'b0), W_SD);
    apply_check("R5", mk(O_IMM, 3'b000, 1'b0, 1'b0), W_ADDI);
    apply_check("R9", mk(O_IMM, 3'b111, 1'b1, 1'b0), W_ADDI);
    apply_check("R1", mk(O_IMM, 3'b000, 1'b1, 1'b1), W_ADDI);
  endtask

  task automatic t_branch;
    apply_check("R2", mk(O_BR, 3'b000, 1'b0, 1'b0), W_BR);
    apply_check("R10", mk(O_BR, 3'b111, 1'b1, 1'b0), W_BR);
    apply_check("R10", mk(O_BR, 3'b110, 1'b0, 1'b1), W_BR);
  endtask

  task automatic t_unknown_opcodes;
    apply_check("R11", mk(7'b1101111, 3'b000, 1'b1, 1'b0), W_NONE);
    apply_check("R11", mk(7'b0110111, 3'b111, 1'b0, 1'b1), W_NONE);
    apply_check("R11", mk(7'b0111011, 3'b000, 1'b1, 1'b0), W_NONE);
    apply_check("R11", 32'hFFFF_FFFF, W_NONE);
    apply_check("R6", mk(7'b0110010, 3'b000, 1'b0, 1'b0), W_NONE);
  endtask

  task automatic t_ignored_bits;
    // R12: every field outside 6:0, 14:12 and 30 set to one
    apply_check("R12", mk(O_REG, 3'b000, 1'b0, 1'b1) & ~32'h4000_0000, W_ADD);
    apply_check("R12", mk(O_REG, 3'b000, 1'b1, 1'b1), W_SUB);
    apply_check("R12", mk(O_REG, 3'b110, 1'b0, 1'b1), W_OR);
    apply_check("R12", mk(O_LD, 3'b011, 1'b1, 1'b1), W_LD);
    apply_check("R12", mk(O_SD, 3'b011, 1'b0, 1'b1), W_SD);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_register_ops();
    t_memory_and_imm();
    t_branch();
    t_unknown_opcodes();
    t_ignored_bits();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule